// File: doc/BRIEF.md
# Regulator Mode Control Register

This block is a byte-wide control and status register for one switching regulator channel. It sits at a single address on a simple register bus with address, write enable, read strobe, write data and read data. It stores two operating-mode choices: one for normal running and one for the low-power state. It also stores a bit that selects where the output voltage choice comes from, and a bit that decides how a warm reset treats the voltage settings.

Three resource-select inputs decide which stored mode drives the regulator. If any of them claims the channel, the low-power mode applies. Otherwise the running mode applies. The mode in effect is driven to the regulator as a registered 2-bit code. It is also returned to software in a read-only field of the same register.

On a warm reset the block either fires a one-cycle reload strobe or does nothing. The strobe tells the external voltage registers to reload their defaults and to clear their force-command bit. Doing nothing leaves the voltage untouched. A hardware reset clears the whole register. A software reset clears only the two mode fields.

Top module: `regulator_mode_reg`

## Requirements
- R1: Once a hardware reset is released, a read of the register returns 0x00. At that point `mode_out`, `vsel_from_pins` and `volt_reload` are all 0.
- R2: A write to address 0x12C stores wdata[1:0] as the running mode, wdata[3:2] as the low-power mode, wdata[6] as the voltage-source bit and wdata[7] as the warm-hold bit. A read strobe at that address returns {hold, vsrc, status[1:0], lowpwr[1:0], run[1:0]} on `bus_rdata` one cycle after the strobe.
- R3: Writes to bits 5:4 are ignored. The status field always reports the mode in effect, whatever value was written there.
- R4: When none of the three select inputs is high, `mode_out` and the status field equal the running-mode field. The code is 00 off, 01 forced PWM, 10 eco, 11 forced PWM. They follow a field write or a select change within one clock cycle.
- R5: When any one of `sel_sleep`, `sel_en1` or `sel_en2` is high, `mode_out` and the status field equal the low-power field, using the same codes.
- R6: `vsel_from_pins` equals the stored voltage-source bit. 1 means the resource pins pick the voltage and 0 means the force-command bit does.
- R7: If the warm-hold bit is 0, a rising edge on `warm_rst` produces `volt_reload` high for exactly the one cycle after the clock edge that samples it. If the warm-hold bit is 1, no strobe is produced.
- R8: A software reset clears both mode fields and the status. The warm-hold bit and the voltage-source bit keep their values.
- R9: A hardware reset clears all fields and all outputs, including the mode fields.
- R10: A write to any other address changes nothing. A read strobe at any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst | input | 1 | Synchronous active-high hardware reset, clears everything |
| sw_rst | input | 1 | Synchronous active-high software reset, clears mode fields and status |
| warm_rst | input | 1 | Warm reset request level |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write enable |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one cycle after the strobe |
| sel_sleep | input | 1 | Resource select: sleep pin claims this channel |
| sel_en1 | input | 1 | Resource select: first enable pin claims this channel |
| sel_en2 | input | 1 | Resource select: second enable pin claims this channel |
| mode_out | output | 2 | Mode in effect, driven to the regulator |
| vsel_from_pins | output | 1 | Voltage choice follows the resource pins when high |
| volt_reload | output | 1 | One-cycle strobe to reload the voltage defaults |

## Verification
Several properties are checked on every cycle. `mode_out` is checked against the field chosen by the select inputs one cycle earlier. The reload strobe is checked to last one cycle and to need a warm-reset edge while the hold bit is clear. The voltage-source output is checked to stay put when no write occurs, and reads of foreign addresses are checked to return zero. The bench scenarios cover the rest. They show the exact bit packing of read data and that writes to the status bits are discarded. They also show that a software reset keeps bits 7:6 while a hardware reset clears them, and that foreign-address writes leave the stored value intact.

// File: rtl/regmode_pkg.sv
package regmode_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned MODE_W   = 2;
  localparam int unsigned NUM_SEL  = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF     = 2'b00,
    MODE_PWM     = 2'b01,
    MODE_ECO     = 2'b10,
    MODE_PWM_ALT = 2'b11
  } reg_mode_e;

  typedef struct packed {
    logic              warm_hold;
    logic              vsrc_pins;
    logic [MODE_W-1:0] status;
    logic [MODE_W-1:0] lowpwr;
    logic [MODE_W-1:0] run;
  } ctrl_word_t;
endpackage

// File: rtl/regmode_fields.sv
module regmode_fields
  import regmode_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h12C
) (
  input  logic              clk,
  input  logic              hw_rst,
  input  logic              sw_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [MODE_W-1:0] run_mode,
  output logic [MODE_W-1:0] lowpwr_mode,
  output logic              warm_hold,
  output logic              vsrc_pins
);
  logic       hit;
  ctrl_word_t wd;

  assign hit = wr_en && (addr == REG_ADDR);
  assign wd  = ctrl_word_t'(wdata);

  // Mode fields: cleared by either reset domain.
  always_ff @(posedge clk) begin
    if (hw_rst || sw_rst) begin
      run_mode    <= MODE_OFF;
      lowpwr_mode <= MODE_OFF;
    end else if (hit) begin
      run_mode    <= wd.run;
      lowpwr_mode <= wd.lowpwr;
    end
  end

  // Control bits: hardware-reset domain only.
  always_ff @(posedge clk) begin
    if (hw_rst) begin
      warm_hold <= 1'b0;
      vsrc_pins <= 1'b0;
    end else if (hit) begin
      warm_hold <= wd.warm_hold;
      vsrc_pins <= wd.vsrc_pins;
    end
  end
endmodule

// File: rtl/regmode_status.sv
module regmode_status
  import regmode_pkg::*;
#(
  parameter int unsigned SEL_N = NUM_SEL
) (
  input  logic              clk,
  input  logic              hw_rst,
  input  logic              sw_rst,
  input  logic [SEL_N-1:0]  sel,
  input  logic [MODE_W-1:0] run_mode,
  input  logic [MODE_W-1:0] lowpwr_mode,
  output logic [MODE_W-1:0] status
);
  logic claimed;
  assign claimed = |sel;

  always_ff @(posedge clk) begin
    if (hw_rst || sw_rst) status <= MODE_OFF;
    else                  status <= claimed ? lowpwr_mode : run_mode;
  end
endmodule

// File: rtl/regmode_warm.sv
module regmode_warm (
  input  logic clk,
  input  logic hw_rst,
  input  logic warm_rst,
  input  logic warm_hold,
  output logic reload
);
  logic warm_q;

  always_ff @(posedge clk) begin
    if (hw_rst) begin
      warm_q <= 1'b0;
      reload <= 1'b0;
    end else begin
      warm_q <= warm_rst;
      reload <= warm_rst && !warm_q && !warm_hold;
    end
  end
endmodule

// File: rtl/regulator_mode_reg.sv
module regulator_mode_reg
  import regmode_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h12C
) (
  input  logic              clk,
  input  logic              hw_rst,
  input  logic              sw_rst,
  input  logic              warm_rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              sel_sleep,
  input  logic              sel_en1,
  input  logic              sel_en2,
  output logic [1:0]        mode_out,
  output logic              vsel_from_pins,
  output logic              volt_reload
);
  logic [MODE_W-1:0] run_mode, lowpwr_mode, status;
  logic              warm_hold, vsrc_pins;
  ctrl_word_t        rd_word;

  regmode_fields #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_fields (
    .clk(clk), .hw_rst(hw_rst), .sw_rst(sw_rst), .wr_en(bus_wr),
    .addr(bus_addr), .wdata(bus_wdata), .run_mode(run_mode),
    .lowpwr_mode(lowpwr_mode), .warm_hold(warm_hold), .vsrc_pins(vsrc_pins)
  );

  regmode_status #(.SEL_N(NUM_SEL)) u_status (
    .clk(clk), .hw_rst(hw_rst), .sw_rst(sw_rst),
    .sel({sel_en2, sel_en1, sel_sleep}), .run_mode(run_mode),
    .lowpwr_mode(lowpwr_mode), .status(status)
  );

  regmode_warm u_warm (
    .clk(clk), .hw_rst(hw_rst), .warm_rst(warm_rst),
    .warm_hold(warm_hold), .reload(volt_reload)
  );

  assign rd_word = '{warm_hold: warm_hold, vsrc_pins: vsrc_pins,
                     status: status, lowpwr: lowpwr_mode, run: run_mode};

  always_ff @(posedge clk) begin
    if (hw_rst)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= (bus_addr == REG_ADDR) ? rd_word : '0;
  end

  assign mode_out       = status;
  assign vsel_from_pins = vsrc_pins;
endmodule

// File: rtl/regulator_mode_reg_chk.sv
module regulator_mode_reg_chk #(
  parameter int unsigned ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h12C
) (
  input logic              clk,
  input logic              hw_rst,
  input logic              sw_rst,
  input logic              warm_rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_rdata,
  input logic              sel_sleep,
  input logic              sel_en1,
  input logic              sel_en2,
  input logic [1:0]        mode_out,
  input logic              vsel_from_pins,
  input logic              volt_reload,
  input logic [1:0]        run_f,
  input logic [1:0]        lowpwr_f,
  input logic              hold_f
);
  logic any_sel;
  assign any_sel = sel_sleep | sel_en1 | sel_en2;

  // R4 and R5
  assert_mode_follows_R4_R5: assert property (@(posedge clk) disable iff (hw_rst)
    !sw_rst |=> (mode_out == ($past(any_sel) ? $past(lowpwr_f) : $past(run_f))));

  assert_reload_one_cycle_R7: assert property (@(posedge clk) disable iff (hw_rst)
    volt_reload |=> !volt_reload);

  assert_reload_cause_R7: assert property (@(posedge clk) disable iff (hw_rst)
    volt_reload |-> ($past(warm_rst) && !$past(hold_f)));

  assert_vsrc_stable_R6: assert property (@(posedge clk) disable iff (hw_rst)
    !$past(bus_wr) |-> $stable(vsel_from_pins));

  assert_foreign_read_zero_R10: assert property (@(posedge clk) disable iff (hw_rst)
    ($past(bus_rd) && ($past(bus_addr) != REG_ADDR)) |-> (bus_rdata == 8'h00));

  assert_reset_clears_R9: assert property (@(posedge clk) disable iff (hw_rst)
    $fell(hw_rst) |-> (mode_out == 2'b00 && !volt_reload && !vsel_from_pins && bus_rdata == 8'h00));
endmodule

bind regulator_mode_reg regulator_mode_reg_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .hw_rst(hw_rst), .sw_rst(sw_rst), .warm_rst(warm_rst),
  .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .sel_sleep(sel_sleep), .sel_en1(sel_en1), .sel_en2(sel_en2),
  .mode_out(mode_out), .vsel_from_pins(vsel_from_pins), .volt_reload(volt_reload),
  .run_f(run_mode), .lowpwr_f(lowpwr_mode), .hold_f(warm_hold)
);

// File: tb/regulator_mode_reg_test.sv
module regulator_mode_reg_test;
  localparam int unsigned AW = 12;
  localparam logic [AW-1:0] RA = 12'h12C;

  logic clk = 1'b0;
  logic hw_rst = 1'b1, sw_rst = 1'b0, warm_rst = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic sel_sleep = 1'b0, sel_en1 = 1'b0, sel_en2 = 1'b0;
  logic [1:0] mode_out;
  logic vsel_from_pins, volt_reload;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [7:0] data; string tag; } exp_t;
  exp_t exp_q[$];
  logic rd_pend = 1'b0;

  always #5 clk = ~clk;

  regulator_mode_reg #(.ADDR_W(AW), .REG_ADDR(RA)) uut (
    .clk(clk), .hw_rst(hw_rst), .sw_rst(sw_rst), .warm_rst(warm_rst),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sel_sleep(sel_sleep), .sel_en1(sel_en1), .sel_en2(sel_en2),
    .mode_out(mode_out), .vsel_from_pins(vsel_from_pins), .volt_reload(volt_reload)
  );

  // Monitor: a read captured at a posedge is compared at the following negedge.
  always @(posedge clk) rd_pend <= bus_rd;
  always @(negedge clk) begin
    if (rd_pend) begin
      exp_t e;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL %s: unexpected read data %h, expected none", "R2", bus_rdata);
      end else begin
        e = exp_q.pop_front();
        if (bus_rdata !== e.data) begin
          errors++;
          $display("FAIL %s: rdata %h expected %h", e.tag, bus_rdata, e.data);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
    exp_t e;
    @(negedge clk);
    e.data = exp; e.tag = tag;
    exp_q.push_back(e);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic sels(input logic s, input logic e1, input logic e2);
    @(negedge clk);
    sel_sleep = s; sel_en1 = e1; sel_en2 = e2;
    @(negedge clk);
  endtask

  task automatic pulse_hw();
    @(negedge clk); hw_rst = 1'b1;
    repeat (2) @(negedge clk);
    hw_rst = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        hw_rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 mode_out", {6'd0, mode_out}, 8'h00);
        chk("R1 vsel", {7'd0, vsel_from_pins}, 8'h00);
        chk("R1 reload", {7'd0, volt_reload}, 8'h00);
        rd(RA, 8'h00, "R1");

        // R2/R3/R4: run=10 eco, lowpwr=01, junk in 5:4
        wr(RA, 8'h36);
        @(negedge clk);
        chk("R4 eco", {6'd0, mode_out}, 8'h02);
        rd(RA, 8'h26, "R2_R3");

        // R5: each select alone picks the low-power field
        sels(1'b1, 1'b0, 1'b0); chk("R5 sleep", {6'd0, mode_out}, 8'h01);
        sels(1'b0, 1'b1, 1'b0); chk("R5 en1", {6'd0, mode_out}, 8'h01);
        sels(1'b0, 1'b0, 1'b1); chk("R5 en2", {6'd0, mode_out}, 8'h01);
        sels(1'b0, 1'b0, 1'b0); chk("R4 back", {6'd0, mode_out}, 8'h02);

        // R6: hold=1, vsrc=1, lowpwr=01, run=11
        wr(RA, 8'hC7);
        @(negedge clk);
        chk("R6 vsel", {7'd0, vsel_from_pins}, 8'h01);
        chk("R4 pwm alt", {6'd0, mode_out}, 8'h03);
        rd(RA, 8'hF7, "R2 full");

        // R7: hold set, no strobe
        @(negedge clk); warm_rst = 1'b1;
        @(negedge clk); chk("R7 held", {7'd0, volt_reload}, 8'h00);
        warm_rst = 1'b0;
        wr(RA, 8'h47);
        @(negedge clk); warm_rst = 1'b1;
        @(negedge clk); chk("R7 strobe", {7'd0, volt_reload}, 8'h01);
        @(negedge clk); chk("R7 one cycle", {7'd0, volt_reload}, 8'h00);
        warm_rst = 1'b0;

        // R10: foreign address
        wr(RA + 1, 8'hFF);
        @(negedge clk);
        rd(RA, 8'h77, "R10 unchanged");
        rd(RA + 1, 8'h00, "R10 foreign read");

        // R8: software reset keeps 7:6
        wr(RA, 8'hC9);
        @(negedge clk); sw_rst = 1'b1;
        @(negedge clk); sw_rst = 1'b0;
        chk("R8 mode", {6'd0, mode_out}, 8'h00);
        rd(RA, 8'hC0, "R8");

        // R9: hardware reset clears all
        pulse_hw();
        @(negedge clk);
        chk("R9 vsel", {7'd0, vsel_from_pins}, 8'h00);
        rd(RA, 8'h00, "R9");
        repeat (2) @(negedge clk);
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: timeout, expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule